// File: doc/BRIEF.md
# Stream Cipher Keystream Block Generator

This block turns a 512-bit cipher state, sixteen 32-bit words, into one 64-byte keystream block. The state is run through a fixed number of rounds. Each pair of rounds first mixes the four columns of the 4x4 word matrix and then its four diagonals, using the add-rotate-xor quarter-round mix. When the rounds are done, the untouched input state is added back word by word. The block is then packed into a 512-bit bus whose lowest byte is the first keystream byte.

One input bit picks between a fast 12-round variant and a full-strength 20-round variant. A single start pulse, given while the core is idle, captures the state and the mode. The core answers with a one-cycle done pulse. The keystream stays on the output until the next block completes. Forming the key and nonce words, and XORing the keystream with message data, are left to the surrounding logic.

Top module: `chacha_core`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `busy_o` are 0 and `ks_o` is all zeros until a block completes.
- R2: A quarter round on words (a,b,c,d) performs, in order: a=a+b, d=(d^a) rotated left 16; c=c+d, b=(b^c) rotated left 12; a=a+b, d=(d^a) rotated left 8; c=c+d, b=(b^c) rotated left 7.
- R3: The first round of each pair applies the quarter round to word groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15).
- R4: The second round of each pair applies the quarter round to word groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R5: `mode20_i`=0 selects 12 rounds (6 pairs), and `mode20_i`=1 selects 20 rounds (10 pairs).
- R6: Each output word is the permuted word plus the matching input word, modulo 2^32. The carry out of bit 31 is dropped.
- R7: Word i of the state and of the keystream occupies bits [32i+31:32i], with its least significant byte lowest. Keystream byte 4i+j is therefore bits [32i+8j+7:32i+8j], so the first keystream byte is `ks_o[7:0]`.
- R8: When `start_i` is sampled high while idle, `busy_o` is 1 in the following cycles. For N rounds, `done_o` is 1 exactly N+1 cycles after the accepting edge, with `busy_o` 0 and `ks_o` valid in that same cycle.
- R9: `state_i` and `mode20_i` are sampled only at the accepting edge. `start_i` while busy is ignored and does not change the result or its timing.
- R10: `done_o` is high for exactly one cycle. `ks_o` keeps its value until the next block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a block; accepted only while idle |
| mode20_i | input | 1 | 0: 12 rounds, 1: 20 rounds |
| state_i | input | 512 | Input state, word i at bits [32i+31:32i] |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse: keystream valid |
| ks_o | output | 512 | Keystream block, little-endian packed |

## Verification
After the edge that accepts a start, the bench steps one falling edge at a time. It expects `busy_o` high and `done_o` low through cycle N. It expects the done pulse, idle status and the keystream in cycle N+1: cycle 13 for the 12-round mode and cycle 21 for the 20-round mode. The expected value comes from an arithmetic model written in the bench. In the cycle after the done pulse, the bench expects `done_o` low again and `ks_o` unchanged. On some vectors it drives a competing start with a different state and mode in the middle of a run. The result and its timing must still match the original request. All sampling happens on the falling edge, half a period away from the edge that updates the outputs.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int LANES     = 4;
  localparam int ROWS      = NUM_WORDS / LANES;

  typedef logic [WORD_W-1:0]          word_t;
  typedef word_t [NUM_WORDS-1:0]      block_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ADD  = 2'd2
  } ctrl_state_e;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // matrix position of row r in lane k; diagonal rounds shift lane by row
  function automatic int unsigned mix_index(input int unsigned k,
                                            input int unsigned r,
                                            input logic diag);
    int unsigned lane;
    lane = diag ? ((k + r) % LANES) : k;
    return r * LANES + lane;
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  // first half: shifts 16 and 12
  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
  end

  // second half: shifts 8 and 7
  always_comb begin
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  block_t st_i,
  input  logic   diag_i,
  output block_t st_o
);
  word_t grp_in  [LANES][ROWS];
  word_t grp_out [LANES][ROWS];

  // gather the four words of each lane
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      for (int r = 0; r < ROWS; r++) begin
        grp_in[k][r] = st_i[mix_index(k, r, diag_i)];
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    chacha_qr u_qr (
      .a_i (grp_in[k][0]),
      .b_i (grp_in[k][1]),
      .c_i (grp_in[k][2]),
      .d_i (grp_in[k][3]),
      .a_o (grp_out[k][0]),
      .b_o (grp_out[k][1]),
      .c_o (grp_out[k][2]),
      .d_o (grp_out[k][3])
    );
  end

  // scatter results back to their matrix positions
  always_comb begin
    st_o = st_i;
    for (int k = 0; k < LANES; k++) begin
      for (int r = 0; r < ROWS; r++) begin
        st_o[mix_index(k, r, diag_i)] = grp_out[k][r];
      end
    end
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int ROUNDS_LO = 12,
  parameter int ROUNDS_HI = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode20_i,
  output logic load_o,
  output logic step_o,
  output logic diag_o,
  output logic add_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ROUNDS_HI + 1);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(ROUNDS_LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(ROUNDS_HI);

  ctrl_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  rounds_q, rounds_d;
  logic              done_q, done_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rounds_d = rounds_q;
    done_d   = 1'b0;
    load_o   = 1'b0;
    step_o   = 1'b0;
    add_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o   = 1'b1;
          cnt_d    = '0;
          rounds_d = mode20_i ? HI_C : LO_C;
          state_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == rounds_q - 1'b1) state_d = ST_ADD;
      end
      ST_ADD: begin
        add_o   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // even counts are column rounds, odd counts diagonal rounds
  assign diag_o = cnt_q[0];
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rounds_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_o || step_o) cnt_q <= cnt_d;
      if (load_o) rounds_q <= rounds_d;
    end
  end

  AST_ROUNDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rounds_q == LO_C || rounds_q == HI_C)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q < rounds_q)); // R5
  AST_DONE_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(state_q) == ST_ADD)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(rounds_q)); // R9
  AST_ROUND_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && $past(step_o)) |-> (diag_o != $past(diag_o))); // R4
endmodule

// File: rtl/chacha_core.sv
module chacha_core
  import chacha_pkg::*;
#(
  parameter int ROUNDS_LO = 12,
  parameter int ROUNDS_HI = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode20_i,
  input  logic [511:0] state_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [511:0] ks_o
);
  block_t work_q, work_d;
  block_t orig_q, orig_d;
  block_t ks_q,   ks_d;
  block_t round_out;
  logic   load, step, diag, add_now;

  chacha_ctrl #(
    .ROUNDS_LO (ROUNDS_LO),
    .ROUNDS_HI (ROUNDS_HI)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mode20_i (mode20_i),
    .load_o   (load),
    .step_o   (step),
    .diag_o   (diag),
    .add_o    (add_now),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  chacha_round u_round (
    .st_i   (work_q),
    .diag_i (diag),
    .st_o   (round_out)
  );

  always_comb begin
    work_d = work_q;
    orig_d = orig_q;
    ks_d   = ks_q;
    if (load) begin
      work_d = block_t'(state_i);
      orig_d = block_t'(state_i);
    end else if (step) begin
      work_d = round_out;
    end
    if (add_now) begin
      for (int i = 0; i < NUM_WORDS; i++) ks_d[i] = work_q[i] + orig_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      orig_q <= '0;
      ks_q   <= '0;
    end else begin
      if (load || step) work_q <= work_d;
      if (load)         orig_q <= orig_d;
      if (add_now)      ks_q   <= ks_d;
    end
  end

  assign ks_o = ks_q;

  AST_ORIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(orig_q)); // R9
  AST_KS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !add_now |=> $stable(ks_q)); // R10
  AST_KS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ks_q) |-> done_o); // R10
endmodule

// File: tb/chacha_core_bench.sv
module chacha_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 20;
  localparam int WATCHDOG   = 150000;

  typedef logic [15:0][31:0] blk_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         mode20_i = 1'b0;
  logic [511:0] state_i = '0;
  logic         busy_o, done_o;
  logic [511:0] ks_o;

  int checks = 0;
  int errs = 0;
  int cyc = 0;

  chacha_core u_chacha_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mode20_i (mode20_i),
    .state_i  (state_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ks_o     (ks_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errs = errs + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // R2 quarter round on positions a,b,c,d
  function automatic blk_t qr(input blk_t x, input int a, input int b,
                              input int c, input int d);
    x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
    x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 12);
    x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
    x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 7);
    return x;
  endfunction

  function automatic blk_t model(input blk_t s, input logic m20);
    blk_t w = s;
    int pairs = m20 ? 10 : 6;                     // R5
    for (int p = 0; p < pairs; p++) begin
      w = qr(w, 0, 4, 8, 12);  w = qr(w, 1, 5, 9, 13);   // R3
      w = qr(w, 2, 6, 10, 14); w = qr(w, 3, 7, 11, 15);
      w = qr(w, 0, 5, 10, 15); w = qr(w, 1, 6, 11, 12);  // R4
      w = qr(w, 2, 7, 8, 13);  w = qr(w, 3, 4, 9, 14);
    end
    for (int i = 0; i < 16; i++) w[i] = w[i] + s[i];  // R6
    return w;
  endfunction

  function automatic blk_t pattern(input int v);
    blk_t s;
    logic [31:0] x = 32'h9e3779b9 ^ (v * 32'h01000193);
    for (int i = 0; i < 16; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      s[i] = x;
    end
    if (v == 0) s = '0;
    if (v == 1) s = '1;
    if (v == 2) begin
      s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
      s[4] = 32'h03020100; s[5] = 32'h07060504; s[6] = 32'h0b0a0908; s[7] = 32'h0f0e0d0c;
      s[8] = 32'h13121110; s[9] = 32'h17161514; s[10] = 32'h1b1a1918; s[11] = 32'h1f1e1d1c;
      s[12] = 32'h00000001; s[13] = 32'h09000000; s[14] = 32'h4a000000; s[15] = 32'h00000000;
    end
    if (v == 3) for (int i = 0; i < 16; i++) s[i] = 32'h1 << (i * 2);
    return s;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input blk_t s, input logic m, input logic interfere);
    blk_t exp = model(s, m);
    int   n   = m ? 20 : 12;
    logic lat_ok = 1'b1;
    @(negedge clk);
    state_i = s; mode20_i = m; start_i = 1'b1;
    @(negedge clk);                 // accepting edge has passed
    start_i = 1'b0;
    state_i = ~s;                   // R9: not sampled after acceptance
    for (int k = 1; k <= n + 1; k++) begin
      if (k == 3 && interfere) begin start_i = 1'b1; mode20_i = ~m; end
      if (k == 4) start_i = 1'b0;
      @(negedge clk);
      if (k <= n && (done_o || !busy_o)) lat_ok = 1'b0;
    end
    check(lat_ok && done_o && !busy_o, "R8 R5", "done timing (done,busy)",
          {510'd0, done_o, busy_o}, {510'd0, 2'b10});
    check(ks_o == exp, "R2 R3 R4 R6", "keystream", ks_o, exp);
    if (interfere)
      check(ks_o == exp, "R9", "result after start while busy", ks_o, exp);
    @(negedge clk);
    check(!done_o && ks_o == exp, "R10", "done pulse width / hold",
          {ks_o[510:0], done_o}, {exp[510:0], 1'b0});
  endtask

  initial begin
    blk_t s;
    check(!done_o && !busy_o && ks_o == '0, "R1", "in reset",
          {ks_o[509:0], done_o, busy_o}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !busy_o && ks_o == '0, "R1", "after reset",
          {ks_o[509:0], done_o, busy_o}, '0);

    // R7: known 20-round vector, first byte and word 0 position
    s = pattern(2);
    run_vec(s, 1'b1, 1'b0);
    check(ks_o[31:0] == 32'he4e7f110, "R7", "word 0 position",
          {480'd0, ks_o[31:0]}, {480'd0, 32'he4e7f110});
    check(ks_o[7:0] == 8'h10, "R7", "first keystream byte",
          {504'd0, ks_o[7:0]}, {504'd0, 8'h10});

    // R9: idle inputs without start leave the output untouched
    @(negedge clk);
    state_i = '1; mode20_i = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy_o && ks_o == model(s, 1'b1), "R9", "idle without start",
          ks_o, model(s, 1'b1));

    for (int v = 0; v < NVEC; v++) begin
      run_vec(pattern(v), 1'b0, v[0]);
      run_vec(pattern(v), 1'b1, ~v[0]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule